// File: doc/BRIEF.md
# Asynchronous Character Transmitter

This block turns parallel characters into asynchronous serial frames on one output line. Each frame has a low start bit, five to eight data bits sent least significant bit first, an optional parity bit and one, one and a half or two high stop bits. The line speed is set by a rate tick input together with a selectable clock factor. The factor is the number of rate ticks that make up one bit cell. A one-character holding register takes data over a valid/ready handshake. The serializer pulls from that register only at a bit-cell boundary.

Transmission is gated by an enable input. With the automatic-enable option on, it is also gated by an active-low clear-to-send input. That gate is tested only when a character is about to start, so a character already on the line always runs to its end. A break request forces the line low on whole bit-cell boundaries. An all-sent flag reports when no data is waiting and the last stop bit has fully left the line. A request-to-send output follows a control bit. The clear-to-send level is also reported back as a status output.

Handshake rules: a character is taken on any clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high exactly when the holding register is empty. While `in_ready` is low, `in_valid` and `in_data` are ignored, and the source must keep the character until it is taken.

Top module: `async_tx`

## Requirements
- R1: After reset, and whenever no character is queued or being sent and no break is active, `txd` is high, `in_ready` is high and `all_sent` is high.
- R2: `in_ready` is high exactly when the holding register is empty. A character is stored on an edge where `in_valid` and `in_ready` are both high. While `in_ready` is low, `in_valid` and `in_data` have no effect.
- R3: A frame begins with one low start bit, followed by 5 + `cfg_len` data bits (`cfg_len` 0..3 gives 5..8 bits), taken from `in_data` least significant bit first. Higher data bits are not sent.
- R4: When `cfg_par_en` is 1, one parity bit follows the data bits. With `cfg_par_odd` = 0, the count of ones in the data bits plus parity is even. With `cfg_par_odd` = 1, it is odd.
- R5: `cfg_stop` = 0 gives one stop bit, 2 or 3 gives two stop bits, and 1 gives one and a half stop bits. In that last case the next start bit begins half a cell after the first stop cell. At factor 1x, setting 1 gives one stop bit.
- R6: `cfg_div` selects how many rate ticks make one bit cell: 0 gives 1, 1 gives 16, 2 gives 32, 3 gives 64. Frames start only on a bit-cell boundary.
- R7: A character starts only while `tx_en` is 1. While it is 0, a queued character stays queued and `txd` stays high.
- R8: With `auto_en` = 1, a character starts only while `cts_n` is low. Raising `cts_n` during a character lets that character finish but holds the next one. With `auto_en` = 0, `cts_n` does not gate transmission.
- R9: `cts_stat` equals the inverse of `cts_n` as sampled on the previous clock edge, whatever `auto_en` is.
- R10: Once `brk_req` is set, `txd` goes low at the first bit-cell boundary and stays low. Once `brk_req` is cleared, `txd` is released at the first bit-cell boundary that follows.
- R11: `all_sent` is high only when the holding register is empty and the serializer is idle. After a character, it rises on the clock edge that ends the last stop cell.
- R12: `rts_n` is the inverse of `rts_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_tick | input | 1 | One pulse per rate tick (clock factor times the bit rate) |
| cfg_div | input | 2 | Clock factor select (1, 16, 32, 64 ticks per cell) |
| cfg_len | input | 2 | Data bits per character minus five |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | Odd parity when 1, even when 0 |
| cfg_stop | input | 2 | Stop length select |
| tx_en | input | 1 | Transmitter enable |
| auto_en | input | 1 | Gate character starts with clear-to-send |
| brk_req | input | 1 | Break request |
| rts_req | input | 1 | Request-to-send control bit |
| cts_n | input | 1 | Active-low clear-to-send |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Holding register empty |
| in_data | input | 8 | Character to send |
| txd | output | 1 | Serial line, idle high |
| rts_n | output | 1 | Active-low request-to-send |
| cts_stat | output | 1 | Clear-to-send status |
| all_sent | output | 1 | No data waiting and the last stop bit has left the line |

## Verification
The bench times the one-and-a-half stop case from one start bit to the next. A design that rounds it to one or two full cells, or that loses bit-cell alignment afterwards, shows a wrong start-to-start gap. It drops `cts_n` in the middle of a character and checks that this character finishes intact while the next one waits. A design that cuts the character short, or that ignores the gate, sends a wrong or extra frame. It times the rise of `all_sent` to the exact cycle the last stop cell ends, and times break entry and exit against the known cell grid. An early flag or a mid-cell transition breaks those counts. It also holds `in_valid` high against a full register while the transmitter is disabled. A design that overwrites the holding register then sends the wrong byte or an extra frame.

// File: rtl/stx_pkg.sv
package stx_pkg;
  localparam int CHAR_W  = 8;
  localparam int DIV_MAX = 64;
  localparam int CNT_W   = $clog2(DIV_MAX);
  localparam int LIM_W   = CNT_W + 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP1,
    ST_STOP2,
    ST_STOPH
  } tx_state_e;

  // rate ticks per bit cell for each factor select
  function automatic logic [LIM_W-1:0] div_limit(input logic [1:0] sel);
    case (sel)
      2'd0:    div_limit = LIM_W'(1);
      2'd1:    div_limit = LIM_W'(16);
      2'd2:    div_limit = LIM_W'(32);
      default: div_limit = LIM_W'(64);
    endcase
  endfunction

  // data bits that belong to the character for a length select
  function automatic logic [CHAR_W-1:0] char_mask(input logic [1:0] len_sel);
    char_mask = {CHAR_W{1'b1}} >> (2'd3 - len_sel);
  endfunction

  function automatic int char_bits(input logic [1:0] len_sel);
    char_bits = CHAR_W - 3 + int'(len_sel);
  endfunction
endpackage

// File: rtl/stx_cell_timer.sv
module stx_cell_timer
  import stx_pkg::*;
#(
  parameter int TICKS_MAX = DIV_MAX
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rate_tick,
  input  logic [1:0] cfg_div,
  input  logic       realign,
  output logic       cell_edge,
  output logic       half_edge
);
  localparam int TW = $clog2(TICKS_MAX) + 1;
  localparam logic [TW-1:0] ONE = TW'(1);

  logic [TW-2:0] cnt;
  logic [TW-1:0] lim;

  assign lim       = TW'(div_limit(cfg_div));
  assign cell_edge = rate_tick && ({1'b0, cnt} >= lim - ONE);
  assign half_edge = rate_tick && (lim != ONE) && ({1'b0, cnt} == (lim >> 1) - ONE);

  always_ff @(posedge clk) begin
    if (!rst_n)                     cnt <= '0;
    else if (realign || cell_edge)  cnt <= '0;
    else if (rate_tick)             cnt <= cnt + 1'b1;
  end

  // R6
  edge_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_edge && lim != ONE) |=> (!cell_edge || lim == ONE));
endmodule

// File: rtl/stx_hold.sv
module stx_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  input  logic         take,
  output logic         in_ready,
  output logic         full,
  output logic [W-1:0] data
);
  logic accept;
  assign accept   = in_valid && !full;
  assign in_ready = !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (accept) begin
      full <= 1'b1;
      data <= in_data;
    end else if (take) begin
      full <= 1'b0;
    end
  end

  // R2
  take_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full);
  // R2
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !take) |=> (full && $stable(data)));
endmodule

// File: rtl/stx_framer.sv
module stx_framer
  import stx_pkg::*;
#(
  parameter int CHAR_MAX = CHAR_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cell_edge,
  input  logic                half_edge,
  input  logic [1:0]          cfg_len,
  input  logic                cfg_par_en,
  input  logic                cfg_par_odd,
  input  logic [1:0]          cfg_stop,
  input  logic [1:0]          cfg_div,
  input  logic                allow_start,
  input  logic                hold_full,
  input  logic [CHAR_MAX-1:0] hold_data,
  output logic                take,
  output logic                realign,
  output logic                line,
  output logic                idle
);
  localparam int NB_W = $clog2(CHAR_MAX);

  tx_state_e           st;
  logic [CHAR_MAX-1:0] sh;
  logic [NB_W-1:0]     nbit;
  logic                parb;
  logic [NB_W-1:0]     last_idx;
  logic                stop_single;
  logic                end_frame;
  logic                launch;

  assign last_idx    = NB_W'(char_bits(cfg_len) - 1);
  assign stop_single = (cfg_stop == 2'd0) || (cfg_stop == 2'd1 && cfg_div == 2'd0);
  assign end_frame   = (st == ST_IDLE  && cell_edge)
                    || (st == ST_STOP1 && cell_edge && stop_single)
                    || (st == ST_STOP2 && cell_edge)
                    || (st == ST_STOPH && half_edge);
  assign launch      = end_frame && allow_start && hold_full;
  assign take        = launch;
  assign realign     = (st == ST_STOPH) && half_edge;
  assign idle        = (st == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      line <= 1'b1;
      sh   <= '0;
      nbit <= '0;
      parb <= 1'b0;
    end else if (launch) begin
      st   <= ST_START;
      line <= 1'b0;
      sh   <= hold_data;
      nbit <= '0;
      parb <= (^(hold_data & char_mask(cfg_len))) ^ cfg_par_odd;
    end else if (end_frame) begin
      st   <= ST_IDLE;
      line <= 1'b1;
    end else if (cell_edge) begin
      case (st)
        ST_START: begin
          st   <= ST_DATA;
          line <= sh[0];
          sh   <= sh >> 1;
        end
        ST_DATA: begin
          if (nbit == last_idx) begin
            st   <= cfg_par_en ? ST_PAR : ST_STOP1;
            line <= cfg_par_en ? parb : 1'b1;
          end else begin
            line <= sh[0];
            sh   <= sh >> 1;
            nbit <= nbit + 1'b1;
          end
        end
        ST_PAR: begin
          st   <= ST_STOP1;
          line <= 1'b1;
        end
        ST_STOP1: begin
          st   <= (cfg_stop == 2'd1) ? ST_STOPH : ST_STOP2;
          line <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R3
  data_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DATA) |-> (nbit <= last_idx));
  // R5
  half_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STOPH) |-> (cfg_div != 2'd0));
  // R4
  par_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PAR) |-> cfg_par_en);
endmodule

// File: rtl/async_tx.sv
module async_tx
  import stx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rate_tick,
  input  logic [1:0]  cfg_div,
  input  logic [1:0]  cfg_len,
  input  logic        cfg_par_en,
  input  logic        cfg_par_odd,
  input  logic [1:0]  cfg_stop,
  input  logic        tx_en,
  input  logic        auto_en,
  input  logic        brk_req,
  input  logic        rts_req,
  input  logic        cts_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  output logic        txd,
  output logic        rts_n,
  output logic        cts_stat,
  output logic        all_sent
);
  logic              cell_edge, half_edge, realign;
  logic              take, hold_full, line, idle;
  logic [CHAR_W-1:0] hold_data;
  logic              allow_start;
  logic              brk_act;

  assign allow_start = tx_en && (!auto_en || !cts_n);

  stx_cell_timer #(.TICKS_MAX(DIV_MAX)) u_timer (
    .clk(clk), .rst_n(rst_n), .rate_tick(rate_tick), .cfg_div(cfg_div),
    .realign(realign), .cell_edge(cell_edge), .half_edge(half_edge)
  );

  stx_hold #(.W(CHAR_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .take(take), .in_ready(in_ready), .full(hold_full), .data(hold_data)
  );

  stx_framer #(.CHAR_MAX(CHAR_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .cell_edge(cell_edge), .half_edge(half_edge),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop(cfg_stop), .cfg_div(cfg_div), .allow_start(allow_start),
    .hold_full(hold_full), .hold_data(hold_data), .take(take),
    .realign(realign), .line(line), .idle(idle)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      brk_act  <= 1'b0;
      cts_stat <= 1'b0;
    end else begin
      cts_stat <= !cts_n;
      if (cell_edge) brk_act <= brk_req;
    end
  end

  assign txd      = brk_act ? 1'b0 : line;
  assign rts_n    = !rts_req;
  assign all_sent = idle && !hold_full;

  // R10
  brk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_edge && brk_req) |=> !txd);
  // R1
  idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (all_sent && !brk_act) |-> txd);
  // R8
  cts_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> $past(tx_en && (!auto_en || !cts_n)));
  // R9
  cts_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cts_n |=> cts_stat);
  // R9
  cts_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cts_n |=> !cts_stat);
  // R11
  sent_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(all_sent) |-> $past(cell_edge || half_edge));
endmodule

// File: tb/async_tx_bench.sv
`timescale 1ns/1ps
module async_tx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rate_tick = 1'b1;
  logic [1:0] cfg_div = 2'd1, cfg_len = 2'd3, cfg_stop = 2'd0;
  logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
  logic       tx_en = 1'b1, auto_en = 1'b0, brk_req = 1'b0, rts_req = 1'b0, cts_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready, txd, rts_n, cts_stat, all_sent;

  typedef struct { logic [11:0] bits; int n; } frame_t;
  frame_t exp_q[$];

  int  total = 0, bad = 0, frames = 0, cyc = 0, cpb = 16;
  int  last_start = 0, prev_start = 0;
  bit  mon_on = 1'b1, done = 1'b0, prev_txd = 1'b1;

  async_tx u_async_tx (
    .clk(clk), .rst_n(rst_n), .rate_tick(rate_tick), .cfg_div(cfg_div),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop(cfg_stop), .tx_en(tx_en), .auto_en(auto_en), .brk_req(brk_req),
    .rts_req(rts_req), .cts_n(cts_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .txd(txd), .rts_n(rts_n), .cts_stat(cts_stat),
    .all_sent(all_sent)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [1:0] dv, input logic [1:0] ln, input bit pe,
                         input bit po, input logic [1:0] sp);
    @(negedge clk);
    cfg_div = dv; cfg_len = ln; cfg_par_en = pe; cfg_par_odd = po; cfg_stop = sp;
    cpb = (dv == 2'd0) ? 1 : (dv == 2'd1) ? 16 : (dv == 2'd2) ? 32 : 64;
  endtask

  // driver: push the expected frame, then hand the byte over when ready
  task automatic send(input logic [7:0] d);
    frame_t f;
    int len;
    logic p;
    len = 5 + int'(cfg_len);
    f.bits = '0; f.n = 0;
    f.bits[f.n] = 1'b0; f.n++;
    p = cfg_par_odd;
    for (int i = 0; i < len; i++) begin
      f.bits[f.n] = d[i]; f.n++;
      p = p ^ d[i];
    end
    if (cfg_par_en) begin f.bits[f.n] = p; f.n++; end
    for (int s = 0; s < ((cfg_stop >= 2'd2) ? 2 : 1); s++) begin
      f.bits[f.n] = 1'b1; f.n++;
    end
    exp_q.push_back(f);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!all_sent || exp_q.size() != 0) @(negedge clk);
    repeat (2 * cpb + 2) @(negedge clk);
  endtask

  // monitor: find each start bit, sample every cell centre, compare
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on && prev_txd && !txd) begin
        frame_t f;
        logic [11:0] act;
        prev_start = last_start;
        last_start = cyc;
        frames++;
        act = '0;
        repeat ((cpb - 1) / 2) @(negedge clk);
        act[0] = txd;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected frame", int'(act), 0);
          repeat (10 * cpb) @(negedge clk);
        end else begin
          f = exp_q.pop_front();
          for (int k = 1; k < f.n; k++) begin
            repeat (cpb) @(negedge clk);
            act[k] = txd;
          end
          chk(act == f.bits, "R3 R4 R5 frame bits", int'(act), int'(f.bits));
        end
      end
      prev_txd = txd;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int t0, f0, c0;
    bit ok;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(txd && in_ready && all_sent, "R1 during reset", {txd, in_ready, all_sent}, 3'b111);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(txd && in_ready && all_sent, "R1 after reset", {txd, in_ready, all_sent}, 3'b111);

    // R3 R6: 16x, 8 data, no parity, 1 stop, back to back
    set_cfg(2'd1, 2'd3, 1'b0, 1'b0, 2'd0);
    send(8'hA5); send(8'h3C);
    wait_idle();
    chk(last_start - prev_start == 160, "R6 16x back-to-back gap", last_start - prev_start, 160);

    // R4: 7 data even parity; upper bit must not be sent
    set_cfg(2'd1, 2'd2, 1'b1, 1'b0, 2'd0);
    send(8'hF1);
    wait_idle();
    // R4 R5: 5 data odd parity two stops
    set_cfg(2'd1, 2'd0, 1'b1, 1'b1, 2'd2);
    send(8'h1B); send(8'h04);
    wait_idle();
    chk(last_start - prev_start == 144, "R5 two-stop gap", last_start - prev_start, 144);

    // R5: one and a half stops at 16x
    set_cfg(2'd1, 2'd3, 1'b0, 1'b0, 2'd1);
    send(8'h81); send(8'h7E);
    wait_idle();
    chk(last_start - prev_start == 168, "R5 1.5 stop gap", last_start - prev_start, 168);
    // R5 R6: at 1x the half setting is one stop
    set_cfg(2'd0, 2'd3, 1'b0, 1'b0, 2'd1);
    send(8'hC3); send(8'h5A);
    wait_idle();
    chk(last_start - prev_start == 10, "R5 1x stop gap", last_start - prev_start, 10);

    // R6: 32x and 64x
    set_cfg(2'd2, 2'd3, 1'b1, 1'b1, 2'd0);
    send(8'h96);
    wait_idle();
    set_cfg(2'd3, 2'd1, 1'b0, 1'b0, 2'd0);
    send(8'h2D);
    wait_idle();

    // R11: all_sent rises exactly when the last stop cell ends
    set_cfg(2'd1, 2'd3, 1'b0, 1'b0, 2'd0);
    send(8'h55);
    @(negedge clk);
    chk(!all_sent, "R11 low with data queued", all_sent, 0);
    while (!all_sent) @(negedge clk);
    chk(cyc - last_start == 160, "R11 rise cycle", cyc - last_start, 160);
    wait_idle();

    // R7 R2: disabled, register full, extra writes ignored
    f0 = frames;
    tx_en = 1'b0;
    send(8'h69);
    ok = 1'b1;
    in_valid = 1'b1; in_data = 8'hEE;
    repeat (150) begin
      @(negedge clk);
      if (!txd) ok = 1'b0;
    end
    in_valid = 1'b0;
    chk(ok, "R7 line high while disabled", 0, 1);
    chk(!in_ready, "R2 ready low while full", in_ready, 0);
    chk(!all_sent, "R11 low while queued", all_sent, 0);
    tx_en = 1'b1;
    wait_idle();
    repeat (300) @(negedge clk);
    chk(frames == f0 + 1, "R2 write while full ignored", frames - f0, 1);

    // R8 R9: auto enable with clear-to-send
    auto_en = 1'b1; cts_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!cts_stat, "R9 status with cts_n high", cts_stat, 0);
    f0 = frames;
    send(8'hB4);
    ok = 1'b1;
    repeat (200) begin
      @(negedge clk);
      if (!txd) ok = 1'b0;
    end
    chk(ok && frames == f0, "R8 held by cts_n high", frames - f0, 0);
    cts_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(cts_stat, "R9 status with cts_n low", cts_stat, 1);
    wait_idle();
    f0 = frames;
    send(8'h4B);
    while (txd) @(negedge clk);
    cts_n = 1'b1;
    send(8'hD2);
    repeat (400) @(negedge clk);
    chk(frames == f0 + 1, "R8 character in progress finishes, next held", frames - f0, 1);
    chk(!in_ready, "R8 next character still queued", in_ready, 0);
    cts_n = 1'b0;
    wait_idle();
    chk(frames == f0 + 2, "R8 held character sent after release", frames - f0, 2);
    auto_en = 1'b0; cts_n = 1'b1;
    send(8'h0F);
    wait_idle();
    cts_n = 1'b0;

    // R10: break aligned to the cell grid of the last 16x, 1-stop frame
    mon_on = 1'b0;
    @(negedge clk);
    brk_req = 1'b1; c0 = cyc;
    @(negedge clk);
    while (txd) @(negedge clk);
    t0 = cyc;
    chk(t0 - c0 >= 1 && t0 - c0 <= 16, "R10 break entry latency", t0 - c0, 16);
    chk((t0 - last_start) % 16 == 0, "R10 break entry on boundary", (t0 - last_start) % 16, 0);
    ok = 1'b1;
    repeat (100) begin
      @(negedge clk);
      if (txd) ok = 1'b0;
    end
    chk(ok, "R10 line held low", 0, 1);
    repeat (3) @(negedge clk);
    brk_req = 1'b0; c0 = cyc;
    @(negedge clk);
    while (!txd) @(negedge clk);
    t0 = cyc;
    chk(t0 - c0 >= 1 && t0 - c0 <= 16, "R10 break exit latency", t0 - c0, 16);
    chk((t0 - last_start) % 16 == 0, "R10 break exit on boundary", (t0 - last_start) % 16, 0);
    repeat (40) @(negedge clk);
    chk(txd && all_sent, "R1 idle after break", {txd, all_sent}, 2'b11);
    mon_on = 1'b1;

    // R12
    rts_req = 1'b1;
    @(negedge clk);
    chk(!rts_n, "R12 rts asserted", rts_n, 0);
    rts_req = 1'b0;
    @(negedge clk);
    chk(rts_n, "R12 rts released", rts_n, 1);

    chk(exp_q.size() == 0, "R3 all expected frames seen", exp_q.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule